// File: doc/BRIEF.md
# Four-Write Flash Command Sequencer

This block sits behind a flash device's bus interface and turns the stream of single-cycle write strobes into commands. A command is accepted only after a fixed sequence of four writes. The first two writes are unlock keys. The third write carries a one-hot command byte. The fourth write supplies the operand address and data, which stay latched for as long as the command runs. Once the fourth write is accepted, the block stays in command mode for a timeout counted in clock cycles. Erase uses a longer window than every other command. When the window ends, the block goes back to plain array reads.

While a command runs, the read-data output comes from one of three sources: a status byte, a manufacturer or device identifier, or array data returned for a verify. Array work (program, erase, both verify polarities and converge) goes to an external array model through a request that stays high until the model pulses done. The block keeps a sticky error flag. A broken unlock sequence sets it, and so do a stalled sequence, a bad command byte, a bad operand or a low-supply indication during execution. Only the reset command clears it.

The FSM has five states. IDLE waits for unlock write 1. KEYED1 waits for unlock write 2. KEYED2 waits for the command write. ARMED waits for the operand write. EXEC runs the command. The transitions are:
- accept-key1 (IDLE→KEYED1)
- accept-key2 (KEYED1→KEYED2)
- accept-code (KEYED2→ARMED)
- launch (ARMED→EXEC)
- abort (KEYED1/KEYED2/ARMED→IDLE on a bad write or an expired gap; EXEC→IDLE on low supply; in IDLE a bad write sets the error flag and the state stays IDLE)
- timeout (EXEC→IDLE)

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode. `rd_src` is 0, `rd_byte` follows `arr_rdata`, `arr_req` and `cmd_active` are low, and the error flag is clear.
- R2: Write 1 must be address 5555h with data AAh. Write 2 must be address 2AAAh with data 55h. Write 3 must be address 5555h. Any other write in these positions sets the error flag and returns the FSM to IDLE.
- R3: Each write after write 1 must arrive within GAP_CYC clock cycles of the previous write. If it does not, the error flag is set at cycle GAP_CYC and the FSM goes to IDLE.
- R4: The command byte must be one of 00h reset, 01h status, 02h ID, 04h verify-0, 08h verify-1, 10h converge, 40h program or 80h erase. Any other value sets the error flag and aborts.
- R5: The operand data must be FFh for erase and 00h for converge. A mismatch sets the error flag, aborts and issues no array request.
- R6: `cmd_active` is high for exactly TO_STD_CYC cycles after the operand write, or TO_ERASE_CYC cycles for erase, and then drops. Writes during this window are ignored.
- R7: `rd_src` is 0 (array) outside command mode. During a command it is 2 for ID, 3 for the verify commands and 1 (status) for all others.
- R8: The status byte has bit 7 set while an array request is outstanding, bit 0 equal to the error flag, and bits 6 to 1 at zero.
- R9: The error flag persists across timeouts and new commands. It is cleared only when a reset command's operand write is accepted.
- R10: During ID read, `rd_byte` is 52h when operand address bit 0 is 0, and DEV_CODE (default 04h) when it is 1.
- R11: During verify, `rd_byte` shows the status byte for VERIFY_CYC cycles after the operand write, then shows `arr_rdata`.
- R12: Array commands raise `arr_req` from the operand write until `arr_done` arrives. `arr_op` is 0 program, 1 erase, 2 verify-0, 3 verify-1 or 4 converge. `arr_addr` and `arr_wdata` hold the operand.
- R13: `low_supply` high during EXEC sets the error flag, drops `arr_req` and returns to read mode on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| low_supply | input | 1 | Supply below lockout level |
| arr_done | input | 1 | Array operation finished (pulse) |
| arr_rdata | input | 8 | Array read data |
| arr_req | output | 1 | Array operation request, held until done |
| arr_op | output | 3 | Array operation code |
| arr_addr | output | ADDR_W | Latched operand address |
| arr_wdata | output | 8 | Latched operand data |
| cmd_active | output | 1 | Command mode (EXEC) |
| rd_src | output | 2 | Read data source select |
| rd_byte | output | 8 | Read data for the bus |

## Verification
The assertions assume that `wr_stb` is a single-cycle pulse with address and data valid in that same cycle. They also assume that `arr_done` comes only while `arr_req` is high, and never in the cycle the request is raised. The bench drives every write as an isolated one-cycle strobe from the falling clock edge. Its array model answers a request only after several cycles and clears itself once the request drops. `low_supply` is only pulsed while a command runs, and only for a short time.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEYED1,
        ST_KEYED2,
        ST_ARMED,
        ST_EXEC
    } seq_state_t;

    typedef enum logic [3:0] {
        CMD_RESET,
        CMD_STATUS,
        CMD_ID,
        CMD_VER0,
        CMD_VER1,
        CMD_CONV,
        CMD_PROG,
        CMD_ERASE,
        CMD_BAD
    } cmd_kind_t;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_ID     = 2'd2,
        SRC_VERIFY = 2'd3
    } rd_src_t;

    typedef enum logic [2:0] {
        OP_PROG  = 3'd0,
        OP_ERASE = 3'd1,
        OP_VER0  = 3'd2,
        OP_VER1  = 3'd3,
        OP_CONV  = 3'd4
    } arr_op_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  MAKER_ID   = 8'h52;
    localparam logic [7:0]  ERASE_KEY  = 8'hFF;
    localparam logic [7:0]  CONV_KEY   = 8'h00;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              key1_ok,
    output logic              key2_ok,
    output logic              code_addr_ok,
    output cmd_kind_t         cmd
);

    always_comb begin
        key1_ok      = (addr == ADDR_W'(KEY_ADDR_A)) && (data == KEY_DATA_A);
        key2_ok      = (addr == ADDR_W'(KEY_ADDR_B)) && (data == KEY_DATA_B);
        code_addr_ok = (addr == ADDR_W'(KEY_ADDR_A));
    end

    always_comb begin
        case (data)
            8'h00:   cmd = CMD_RESET;
            8'h01:   cmd = CMD_STATUS;
            8'h02:   cmd = CMD_ID;
            8'h04:   cmd = CMD_VER0;
            8'h08:   cmd = CMD_VER1;
            8'h10:   cmd = CMD_CONV;
            8'h40:   cmd = CMD_PROG;
            8'h80:   cmd = CMD_ERASE;
            default: cmd = CMD_BAD;
        endcase
    end

    always_comb begin
        if (cmd != CMD_BAD) begin
            assert_code_onehot_R4: assert ($countones(data) <= 1)
                else $error("accepted command byte with several bits set");
        end
    end

endmodule

// File: rtl/flash_gap_watch.sv
module flash_gap_watch #(
    parameter int unsigned GAP_CYC = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wr,
    output logic expired
);

    localparam int unsigned GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (!run || wr) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + GW'(1);
        end
    end

    assign expired = run && !wr && (gap_cnt == GW'(GAP_CYC - 1));

    assert_gap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (gap_cnt < GW'(GAP_CYC)))
        else $error("gap counter ran past its limit while armed");

endmodule

// File: rtl/flash_down_cnt.sv
module flash_down_cnt #(
    parameter int unsigned MAX = 50000,
    parameter int unsigned W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

    assert_load_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val <= W'(MAX)))
        else $error("timer loaded above its maximum");

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W       = 17,
    parameter int unsigned GAP_CYC      = 7500,
    parameter int unsigned TO_STD_CYC   = 12500,
    parameter int unsigned TO_ERASE_CYC = 50000,
    parameter int unsigned VERIFY_CYC   = 1250,
    parameter logic [7:0]  DEV_CODE     = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              low_supply,
    input  logic              arr_done,
    input  logic [7:0]        arr_rdata,
    output logic              arr_req,
    output logic [2:0]        arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              cmd_active,
    output logic [1:0]        rd_src,
    output logic [7:0]        rd_byte
);

    localparam int unsigned TO_MAX = (TO_ERASE_CYC > TO_STD_CYC) ? TO_ERASE_CYC : TO_STD_CYC;
    localparam int unsigned TW     = $clog2(TO_MAX + 1);
    localparam int unsigned VW     = $clog2(VERIFY_CYC + 1);

    seq_state_t        st_q, st_d;
    cmd_kind_t         cmd_q, dec_cmd;
    logic [ADDR_W-1:0] op_addr_q;
    logic [7:0]        op_data_q;
    logic              err_q, pending_q;
    logic              key1_ok, key2_ok, code_addr_ok;
    logic              gap_run, gap_exp;
    logic              err_set, launch, cmd_ld, operand_ok, is_array_cmd;
    logic              to_zero, ver_ready, in_exec;
    logic [TW-1:0]     to_load;
    rd_src_t           src;
    logic [7:0]        status_b, id_b;

    flash_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr         (wr_addr),
        .data         (wr_data),
        .key1_ok      (key1_ok),
        .key2_ok      (key2_ok),
        .code_addr_ok (code_addr_ok),
        .cmd          (dec_cmd)
    );

    assign gap_run = (st_q == ST_KEYED1) || (st_q == ST_KEYED2) || (st_q == ST_ARMED);

    flash_gap_watch #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .wr      (wr_stb),
        .expired (gap_exp)
    );

    assign in_exec = (st_q == ST_EXEC);
    assign to_load = (cmd_q == CMD_ERASE) ? TW'(TO_ERASE_CYC - 1) : TW'(TO_STD_CYC - 1);

    flash_down_cnt #(.MAX(TO_MAX), .W(TW)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (to_load),
        .run      (in_exec),
        .zero     (to_zero)
    );

    flash_down_cnt #(.MAX(VERIFY_CYC), .W(VW)) u_verify_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (VW'(VERIFY_CYC)),
        .run      (in_exec),
        .zero     (ver_ready)
    );

    always_comb begin
        unique case (cmd_q)
            CMD_ERASE: operand_ok = (wr_data == ERASE_KEY);
            CMD_CONV:  operand_ok = (wr_data == CONV_KEY);
            default:   operand_ok = 1'b1;
        endcase
    end

    always_comb begin
        unique case (cmd_q)
            CMD_PROG, CMD_ERASE, CMD_VER0, CMD_VER1, CMD_CONV: is_array_cmd = 1'b1;
            default:                                           is_array_cmd = 1'b0;
        endcase
    end

    // next-state and transition decisions
    always_comb begin
        st_d    = st_q;
        err_set = 1'b0;
        launch  = 1'b0;
        cmd_ld  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_stb) begin
                    if (key1_ok) st_d = ST_KEYED1;
                    else         err_set = 1'b1;
                end
            end
            ST_KEYED1: begin
                if (wr_stb) begin
                    if (key2_ok) begin
                        st_d = ST_KEYED2;
                    end else begin
                        err_set = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end else if (gap_exp) begin
                    err_set = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_KEYED2: begin
                if (wr_stb) begin
                    if (code_addr_ok && (dec_cmd != CMD_BAD)) begin
                        st_d   = ST_ARMED;
                        cmd_ld = 1'b1;
                    end else begin
                        err_set = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end else if (gap_exp) begin
                    err_set = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (wr_stb) begin
                    if (operand_ok) begin
                        st_d   = ST_EXEC;
                        launch = 1'b1;
                    end else begin
                        err_set = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end else if (gap_exp) begin
                    err_set = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_EXEC: begin
                if (low_supply) begin
                    err_set = 1'b1;
                    st_d    = ST_IDLE;
                end else if (to_zero) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // command, operand, error and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_STATUS;
            op_addr_q <= '0;
            op_data_q <= '0;
            err_q     <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            if (cmd_ld) cmd_q <= dec_cmd;
            if (launch) begin
                op_addr_q <= wr_addr;
                op_data_q <= wr_data;
            end
            if (launch && (cmd_q == CMD_RESET)) err_q <= 1'b0;
            else if (err_set)                   err_q <= 1'b1;
            if (launch && is_array_cmd)                 pending_q <= 1'b1;
            else if (in_exec && (low_supply || to_zero)) pending_q <= 1'b0;
            else if (arr_done)                          pending_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        src = SRC_ARRAY;
        if (in_exec) begin
            unique case (cmd_q)
                CMD_ID:             src = SRC_ID;
                CMD_VER0, CMD_VER1: src = SRC_VERIFY;
                default:            src = SRC_STATUS;
            endcase
        end
        status_b = {pending_q, 6'b000000, err_q};
        id_b     = op_addr_q[0] ? DEV_CODE : MAKER_ID;
        unique case (src)
            SRC_ARRAY:  rd_byte = arr_rdata;
            SRC_STATUS: rd_byte = status_b;
            SRC_ID:     rd_byte = id_b;
            SRC_VERIFY: rd_byte = ver_ready ? arr_rdata : status_b;
            default:    rd_byte = arr_rdata;
        endcase
        unique case (cmd_q)
            CMD_ERASE: arr_op = OP_ERASE;
            CMD_VER0:  arr_op = OP_VER0;
            CMD_VER1:  arr_op = OP_VER1;
            CMD_CONV:  arr_op = OP_CONV;
            default:   arr_op = OP_PROG;
        endcase
        rd_src     = src;
        arr_req    = pending_q;
        arr_addr   = op_addr_q;
        arr_wdata  = op_data_q;
        cmd_active = in_exec;
    end

    assert_req_in_exec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> (st_q == ST_EXEC))
        else $error("array request outside command mode");

    assert_operand_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_EXEC) && ($past(st_q) == ST_EXEC)) |-> ($stable(op_addr_q) && $stable(op_data_q)))
        else $error("operand changed during execution");

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(launch && (cmd_q == CMD_RESET)))
        else $error("error flag cleared without a reset command");

    assert_read_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_EXEC) |-> (rd_src == 2'(SRC_ARRAY)))
        else $error("non-array read source outside command mode");

    assert_supply_abort_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_EXEC) && low_supply) |=> ((st_q == ST_IDLE) && err_q && !arr_req))
        else $error("low supply did not abort the command");

    assert_status_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == 2'(SRC_STATUS)) |-> (rd_byte[6:1] == 6'b0))
        else $error("status byte reserved bits not zero");

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

    localparam int GAP  = 20;
    localparam int TOS  = 40;
    localparam int TOE  = 80;
    localparam int VDLY = 10;
    localparam logic [7:0] ARR_VAL = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        low_supply = 1'b0;
    logic        arr_done;
    logic [7:0]  arr_rdata = ARR_VAL;
    logic        arr_req;
    logic [2:0]  arr_op;
    logic [16:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        cmd_active;
    logic [1:0]  rd_src;
    logic [7:0]  rd_byte;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(17), .GAP_CYC(GAP), .TO_STD_CYC(TOS),
        .TO_ERASE_CYC(TOE), .VERIFY_CYC(VDLY), .DEV_CODE(8'h04)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .low_supply(low_supply), .arr_done(arr_done),
        .arr_rdata(arr_rdata), .arr_req(arr_req), .arr_op(arr_op),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .cmd_active(cmd_active),
        .rd_src(rd_src), .rd_byte(rd_byte)
    );

    // array model: answers a request after four cycles
    logic [2:0] mcnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt     <= '0;
            arr_done <= 1'b0;
        end else if (arr_done) begin
            arr_done <= 1'b0;
            mcnt     <= '0;
        end else if (arr_req) begin
            if (mcnt == 3'd3) arr_done <= 1'b1;
            else              mcnt <= mcnt + 3'd1;
        end else begin
            mcnt <= '0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] code, input logic [16:0] a, input logic [7:0] d);
        do_write(17'h05555, 8'hAA);
        do_write(17'h02AAA, 8'h55);
        do_write(17'h05555, code);
        do_write(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_read_mode();
        for (int i = 0; i < 300; i++) begin
            if (!cmd_active) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_err();
        do_cmd(8'h00, 17'h0, 8'h0);
        wait_read_mode();
    endtask

    // {corrupt slot[2], addr[16], data[8], command[8], expect error[1]}
    localparam logic [34:0] VEC [0:8] = '{
        {2'd0, 16'h0000, 8'h00, 8'h01, 1'b0},
        {2'd1, 16'h5554, 8'hAA, 8'h01, 1'b1},
        {2'd1, 16'h5555, 8'hAB, 8'h01, 1'b1},
        {2'd2, 16'h2AAA, 8'h54, 8'h01, 1'b1},
        {2'd2, 16'h2AAB, 8'h55, 8'h01, 1'b1},
        {2'd3, 16'h5556, 8'h00, 8'h01, 1'b1},
        {2'd0, 16'h0000, 8'h00, 8'h03, 1'b1},
        {2'd0, 16'h0000, 8'h00, 8'h20, 1'b1},
        {2'd0, 16'h0000, 8'h00, 8'h00, 1'b0}
    };

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_src", 32'(rd_src), 32'd0);
        chk("R1 rd_byte", 32'(rd_byte), 32'(ARR_VAL));
        chk("R1 arr_req", 32'(arr_req), 32'd0);
        chk("R1 cmd_active", 32'(cmd_active), 32'd0);
        do_cmd(8'h01, 17'h0, 8'h0);
        chk("R1 error flag clear", 32'(rd_byte), 32'h00);
        wait_read_mode();

        // R2/R4 table of unlock and command-byte patterns
        for (int i = 0; i < 9; i++) begin
            automatic logic [34:0] v = VEC[i];
            automatic logic [16:0] a1 = 17'h05555, a2 = 17'h02AAA, a3 = 17'h05555;
            automatic logic [7:0]  d1 = 8'hAA, d2 = 8'h55;
            case (v[34:33])
                2'd1: begin a1 = {1'b0, v[32:17]}; d1 = v[16:9]; end
                2'd2: begin a2 = {1'b0, v[32:17]}; d2 = v[16:9]; end
                2'd3: a3 = {1'b0, v[32:17]};
                default: ;
            endcase
            do_write(a1, d1);
            do_write(a2, d2);
            do_write(a3, v[8:1]);
            do_write(17'h0, 8'h0);
            chk("R2/R4 command mode entry", 32'(cmd_active), 32'(!v[0]));
            wait_read_mode();
            do_cmd(8'h01, 17'h0, 8'h0);
            chk("R2/R4 error bit", 32'(rd_byte), 32'({7'b0, v[0]}));
            wait_read_mode();
            clear_err();
        end

        // R6 exact timeout, standard and erase
        do_cmd(8'h01, 17'h0, 8'h0);
        idle(TOS - 1);
        chk("R6 still active before standard timeout", 32'(cmd_active), 32'd1);
        idle(1);
        chk("R6 inactive at standard timeout", 32'(cmd_active), 32'd0);
        chk("R7 array source after timeout", 32'(rd_src), 32'd0);
        do_cmd(8'h80, 17'h08000, 8'hFF);
        idle(TOE - 1);
        chk("R6 still active before erase timeout", 32'(cmd_active), 32'd1);
        idle(1);
        chk("R6 inactive at erase timeout", 32'(cmd_active), 32'd0);

        // R6 writes ignored during command mode
        do_cmd(8'h01, 17'h0, 8'h0);
        do_write(17'h01234, 8'h77);
        chk("R6 write ignored keeps mode", 32'(cmd_active), 32'd1);
        wait_read_mode();
        do_cmd(8'h01, 17'h0, 8'h0);
        chk("R6 ignored write left no error", 32'(rd_byte), 32'h00);
        wait_read_mode();

        // R12 / R8 program request and busy bit
        do_cmd(8'h40, 17'h01234, 8'h5A);
        chk("R12 arr_req", 32'(arr_req), 32'd1);
        chk("R12 arr_op program", 32'(arr_op), 32'd0);
        chk("R12 arr_addr", 32'(arr_addr), 32'h01234);
        chk("R12 arr_wdata", 32'(arr_wdata), 32'h5A);
        chk("R7 status source", 32'(rd_src), 32'd1);
        chk("R8 busy status", 32'(rd_byte), 32'h80);
        idle(10);
        chk("R12 request dropped after done", 32'(arr_req), 32'd0);
        chk("R8 idle status", 32'(rd_byte), 32'h00);
        wait_read_mode();

        // R12 converge op code
        do_cmd(8'h10, 17'h00100, 8'h00);
        chk("R12 arr_op converge", 32'(arr_op), 32'd4);
        chk("R12 converge request", 32'(arr_req), 32'd1);
        wait_read_mode();

        // R10 identifier reads
        do_cmd(8'h02, 17'h0, 8'h0);
        chk("R7 id source", 32'(rd_src), 32'd2);
        chk("R10 maker id", 32'(rd_byte), 32'h52);
        wait_read_mode();
        do_cmd(8'h02, 17'h1, 8'h0);
        chk("R10 device id", 32'(rd_byte), 32'h04);
        wait_read_mode();

        // R11 verify delay
        do_cmd(8'h04, 17'h00ABC, 8'h0);
        chk("R7 verify source", 32'(rd_src), 32'd3);
        chk("R11 status while delay runs", 32'(rd_byte), 32'h80);
        chk("R12 arr_op verify-0", 32'(arr_op), 32'd2);
        idle(VDLY - 1);
        chk("R11 still status one cycle before", 32'(rd_byte), 32'h00);
        idle(1);
        chk("R11 array data after delay", 32'(rd_byte), 32'(ARR_VAL));
        wait_read_mode();
        do_cmd(8'h08, 17'h00ABC, 8'h0);
        chk("R12 arr_op verify-1", 32'(arr_op), 32'd3);
        wait_read_mode();

        // R5 bad operand for erase and converge
        do_cmd(8'h80, 17'h0, 8'h12);
        chk("R5 erase bad operand not launched", 32'(cmd_active), 32'd0);
        chk("R5 no request", 32'(arr_req), 32'd0);
        do_cmd(8'h01, 17'h0, 8'h0);
        chk("R5 error set", 32'(rd_byte), 32'h01);
        wait_read_mode();
        clear_err();
        do_cmd(8'h10, 17'h0, 8'h01);
        chk("R5 converge bad operand not launched", 32'(cmd_active), 32'd0);
        clear_err();

        // R3 gap limit
        do_write(17'h05555, 8'hAA);
        idle(GAP - 4);
        do_write(17'h02AAA, 8'h55);
        idle(GAP - 4);
        do_write(17'h05555, 8'h01);
        idle(GAP - 4);
        do_write(17'h0, 8'h0);
        chk("R3 slow but in-limit sequence accepted", 32'(cmd_active), 32'd1);
        chk("R3 no error", 32'(rd_byte), 32'h00);
        wait_read_mode();
        do_write(17'h05555, 8'hAA);
        idle(GAP + 4);
        do_cmd(8'h01, 17'h0, 8'h0);
        chk("R3 stalled sequence aborted", 32'(cmd_active), 32'd1);
        chk("R3 stall sets error", 32'(rd_byte), 32'h01);
        wait_read_mode();
        clear_err();

        // R13 low supply during execution, then R9 stickiness
        do_cmd(8'h80, 17'h10000, 8'hFF);
        idle(2);
        low_supply = 1'b1;
        @(negedge clk);
        chk("R13 command aborted", 32'(cmd_active), 32'd0);
        chk("R13 request dropped", 32'(arr_req), 32'd0);
        low_supply = 1'b0;
        do_cmd(8'h01, 17'h0, 8'h0);
        chk("R13 error flag set", 32'(rd_byte), 32'h01);
        wait_read_mode();
        do_cmd(8'h02, 17'h0, 8'h0);
        wait_read_mode();
        do_cmd(8'h01, 17'h0, 8'h0);
        chk("R9 error survives timeouts", 32'(rd_byte), 32'h01);
        wait_read_mode();
        do_cmd(8'h00, 17'h0, 8'h0);
        chk("R9 reset command clears error", 32'(rd_byte), 32'h00);
        wait_read_mode();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule